// File: doc/BRIEF.md
# DDR Bank Precharge Timing Checker

This block sits beside a synchronous DRAM controller and watches the command stream it sends to a four-bank device. It keeps a small state machine and a set of down-counters for each bank. It judges every ACTIVATE, READ, READ-with-autoprecharge and PRECHARGE against the precharge timing rules: the minimum open time of a row (tRAS), the row precharge time (tRP, given in picoseconds and rounded up to whole clocks when the design is built), and the point in a read burst where a precharge no longer cuts the data short.

A read with autoprecharge is modelled as an internal precharge. That precharge starts at the later of two edges: the earliest edge where an explicit precharge would leave the burst whole, and the edge where tRAS is met. Each bank shows two flags that a scheduler can use directly: whether an ACTIVATE would be legal now, and whether a PRECHARGE would be legal now. A command that breaks a rule raises a one-cycle pulse with a reason code and does not change the bank's state.

Top module: `ddr_pre_timing_chk`

## Requirements
- R1: After reset every bank is idle: all activate flags are 1, all precharge flags are 0 and the violation pulse is 0.
- R2: An ACTIVATE to an idle bank opens it, which clears its activate flag. Its precharge flag rises only after TRAS_CYC clocks: a PRECHARGE at edge a+TRAS_CYC is the first legal one after an ACTIVATE at edge a.
- R3: A PRECHARGE to an open bank before tRAS is met reports code 4 and is ignored, so the bank stays open.
- R4: A PRECHARGE to an open bank that meets tRAS is legal at any point of a read burst, including one cycle after the READ. An ACTIVATE to that bank is legal from edge p+ceil(TRP_PS/TCK_PS) and reports code 2 before then.
- R5: An ACTIVATE to a bank that is open or has an autoprecharge pending reports code 1.
- R6: A READ (code 2) or READ with autoprecharge (code 3) to a bank that is not open reports code 3. A bank with an autoprecharge pending counts as not open.
- R7: After a READ with autoprecharge at edge r to a bank activated at edge a, the internal precharge starts at edge max(r+BURST_LEN/2, a+TRAS_CYC), and tRP is counted from that edge.
- R8: A PRECHARGE to a bank with an autoprecharge pending reports code 5. A PRECHARGE to an idle bank is ignored and reports nothing.
- R9: The violation pulse and code appear in the cycle after the offending command's edge and last exactly one cycle. A violating command changes no bank state.
- R10: Commands to one bank never change the flags or timers of another bank.
- R11: Command codes 5 to 7 act as NOP (0). The command codes are NOP=0, ACTIVATE=1, READ=2, READ with autoprecharge=3, PRECHARGE=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Command code sampled at each rising edge |
| bank_i | input | $clog2(NUM_BANKS) | Bank addressed by the command |
| act_ok_o | output | NUM_BANKS | Per bank: an ACTIVATE would be legal now |
| pre_ok_o | output | NUM_BANKS | Per bank: a PRECHARGE would be legal now |
| viol_o | output | 1 | One-cycle pulse for a rule break |
| viol_code_o | output | 3 | Reason of the current pulse (0 when none) |

## Verification
The internal precharge of a bank with an autoprecharge pending can fire in the same cycle that an explicit command to a different bank is judged. The bench sets this up by placing an ACTIVATE to bank 1 on the exact edge where bank 2's autoprecharge, held back by tRAS, starts. It then checks three things: the ACTIVATE raises no pulse, bank 1 is open, and bank 2 regains its activate flag exactly tRP later. A second case lines up the tRAS point and the burst point on separate edges, so the check can tell which of the two actually started the precharge.

// File: rtl/ddr_pre_pkg.sv
package ddr_pre_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_RDA = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE = 3'd0,
    BK_OPEN = 3'd1,
    BK_READ = 3'd2,
    BK_RDAP = 3'd3,
    BK_PRE  = 3'd4
  } bank_st_e;

  typedef enum logic [2:0] {
    VIO_NONE      = 3'd0,
    VIO_ACT_OPEN  = 3'd1,
    VIO_ACT_TRP   = 3'd2,
    VIO_RD_CLOSED = 3'd3,
    VIO_PRE_TRAS  = 3'd4,
    VIO_PRE_AP    = 3'd5
  } vio_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_rst_sync.sv
module ddr_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;
endmodule

// File: rtl/ddr_cmd_dec.sv
module ddr_cmd_dec
  import ddr_pre_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic [2:0]           cmd_raw_i,
  input  logic [BANK_W-1:0]    bank_i,
  output cmd_e                 cmd_o,
  output logic [NUM_BANKS-1:0] sel_o
);

  // Unused codes fold onto NOP so they can never address a bank.
  always_comb begin
    unique case (cmd_raw_i)
      3'd1:    cmd_o = CMD_ACT;
      3'd2:    cmd_o = CMD_RD;
      3'd3:    cmd_o = CMD_RDA;
      3'd4:    cmd_o = CMD_PRE;
      default: cmd_o = CMD_NOP;
    endcase
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
    assign sel_o[b] = (cmd_o != CMD_NOP) && (bank_i == BANK_W'(b));
  end

endmodule

// File: rtl/ddr_bank_fsm.sv
module ddr_bank_fsm
  import ddr_pre_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int TRAS_CYC  = 8,
  parameter int RP_CYC    = 4,
  parameter int PRE_POINT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_i,
  input  cmd_e       cmd_i,
  output logic       act_ok_o,
  output logic       pre_ok_o,
  output logic [2:0] vio_o
);

  localparam logic [CNT_W-1:0] RAS_LOAD = CNT_W'(TRAS_CYC - 1);
  localparam logic [CNT_W-1:0] BST_LOAD = CNT_W'(PRE_POINT - 1);
  localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(RP_CYC - 1);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam bank_st_e         PRE_DEST = (RP_CYC > 1) ? BK_PRE : BK_IDLE;

  bank_st_e         st_q, st_d;
  logic [CNT_W-1:0] ras_q, ras_d;
  logic [CNT_W-1:0] bst_q, bst_d;
  logic [CNT_W-1:0] rp_q, rp_d;
  logic             upd_en;

  logic bank_open;
  logic ras_met;
  logic accept;
  logic ap_fire;
  vio_e vio;

  assign bank_open = (st_q == BK_OPEN) || (st_q == BK_READ);
  assign ras_met   = (ras_q == '0);
  assign act_ok_o  = (st_q == BK_IDLE);
  assign pre_ok_o  = bank_open && ras_met;
  assign ap_fire   = (st_q == BK_RDAP) && (bst_q == '0) && ras_met;

  // Rule check for a command addressed to this bank.
  always_comb begin
    vio = VIO_NONE;
    if (sel_i) begin
      unique case (cmd_i)
        CMD_ACT: begin
          if (st_q == BK_PRE)       vio = VIO_ACT_TRP;
          else if (st_q != BK_IDLE) vio = VIO_ACT_OPEN;
        end
        CMD_RD, CMD_RDA: begin
          if (!bank_open) vio = VIO_RD_CLOSED;
        end
        CMD_PRE: begin
          if (bank_open && !ras_met) vio = VIO_PRE_TRAS;
          else if (st_q == BK_RDAP)  vio = VIO_PRE_AP;
        end
        default: vio = VIO_NONE;
      endcase
    end
  end

  assign vio_o  = vio;
  assign accept = sel_i && (vio == VIO_NONE);

  // Next-state logic: counters saturate at zero.
  always_comb begin
    st_d  = st_q;
    ras_d = ras_met ? ras_q : ras_q - ONE;
    bst_d = (bst_q == '0) ? bst_q : bst_q - ONE;
    rp_d  = (rp_q == '0) ? rp_q : rp_q - ONE;
    unique case (st_q)
      BK_IDLE: begin
        if (accept && cmd_i == CMD_ACT) begin
          st_d  = BK_OPEN;
          ras_d = RAS_LOAD;
        end
      end
      BK_OPEN, BK_READ: begin
        if (accept && cmd_i == CMD_RD) begin
          st_d  = BK_READ;
          bst_d = BST_LOAD;
        end else if (accept && cmd_i == CMD_RDA) begin
          st_d  = BK_RDAP;
          bst_d = BST_LOAD;
        end else if (accept && cmd_i == CMD_PRE) begin
          st_d = PRE_DEST;
          rp_d = RP_LOAD;
        end else if (st_q == BK_READ && bst_q == '0) begin
          st_d = BK_OPEN;
        end
      end
      BK_RDAP: begin
        if (ap_fire) begin
          st_d = PRE_DEST;
          rp_d = RP_LOAD;
        end
      end
      BK_PRE: begin
        if (rp_q <= ONE) st_d = BK_IDLE;
      end
      default: st_d = BK_IDLE;
    endcase
  end

  assign upd_en = sel_i || (st_q != BK_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      ras_q <= '0;
      bst_q <= '0;
      rp_q  <= '0;
    end else if (upd_en) begin
      st_q  <= st_d;
      ras_q <= ras_d;
      bst_q <= bst_d;
      rp_q  <= rp_d;
    end
  end

  p_act_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && cmd_i == CMD_ACT && act_ok_o) |=> !act_ok_o);

  p_early_pre_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && cmd_i == CMD_PRE && bank_open && !ras_met) |=> bank_open);

  p_pre_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && cmd_i == CMD_PRE && pre_ok_o) |=> (!pre_ok_o && !bank_open));

  p_ap_waits_tras_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_RDAP && !ras_met) |=> (st_q == BK_RDAP));

  p_idle_pre_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && cmd_i == CMD_PRE && st_q == BK_IDLE) |=> act_ok_o);

endmodule

// File: rtl/ddr_vio_report.sv
module ddr_vio_report #(
  parameter int NUM_BANKS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_BANKS-1:0]       sel_i,
  input  logic [NUM_BANKS-1:0][2:0]  code_i,
  output logic                       vio_o,
  output logic [2:0]                 code_o
);

  logic [2:0] pick;
  logic [2:0] code_q;

  always_comb begin
    pick = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel_i[b]) pick = code_i[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= pick;
  end

  assign code_o = code_q;
  assign vio_o  = (code_q != '0);

  p_pulse_has_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vio_o |-> $past(|sel_i));

  p_one_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_i));

endmodule

// File: rtl/ddr_pre_timing_chk.sv
module ddr_pre_timing_chk
  import ddr_pre_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 8,
  parameter int TRP_PS    = 18000,
  parameter int TCK_PS    = 5000,
  parameter int TRAS_CYC  = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           cmd_i,
  input  logic [BANK_W-1:0]    bank_i,
  output logic [NUM_BANKS-1:0] act_ok_o,
  output logic [NUM_BANKS-1:0] pre_ok_o,
  output logic                 viol_o,
  output logic [2:0]           viol_code_o
);

  // Double data rate: BURST_LEN beats take BURST_LEN/2 clocks after CAS_LAT.
  localparam int BURST_CYC = BURST_LEN / 2;
  localparam int LAST_DATA = CAS_LAT + BURST_CYC - 1;
  localparam int PRE_POINT = LAST_DATA + 1 - CAS_LAT;
  localparam int RP_CYC    = ceil_div(TRP_PS, TCK_PS);
  localparam int CNT_MAX   = max2(TRAS_CYC, max2(PRE_POINT, RP_CYC));
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  logic                      rst_n_s;
  cmd_e                      cmd;
  logic [NUM_BANKS-1:0]      sel;
  logic [NUM_BANKS-1:0][2:0] bank_vio;

  ddr_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  ddr_cmd_dec #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .cmd_raw_i (cmd_i),
    .bank_i    (bank_i),
    .cmd_o     (cmd),
    .sel_o     (sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ddr_bank_fsm #(
      .CNT_W     (CNT_W),
      .TRAS_CYC  (TRAS_CYC),
      .RP_CYC    (RP_CYC),
      .PRE_POINT (PRE_POINT)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .sel_i    (sel[b]),
      .cmd_i    (cmd),
      .act_ok_o (act_ok_o[b]),
      .pre_ok_o (pre_ok_o[b]),
      .vio_o    (bank_vio[b])
    );
  end

  ddr_vio_report #(.NUM_BANKS(NUM_BANKS)) u_rep (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .sel_i  (sel),
    .code_i (bank_vio),
    .vio_o  (viol_o),
    .code_o (viol_code_o)
  );

endmodule

// File: tb/tb_ddr_pre_timing_chk.sv
module tb_ddr_pre_timing_chk;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 5000;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, RDA = 3'd3, PRE = 3'd4;
  localparam logic [2:0] C_NONE = 3'd0, C_ACT_OPEN = 3'd1, C_ACT_TRP = 3'd2,
                         C_RD_CLOSED = 3'd3, C_PRE_TRAS = 3'd4, C_PRE_AP = 3'd5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] cmd;
  logic [1:0] bank;
  logic [3:0] act_ok;
  logic [3:0] pre_ok;
  logic       viol;
  logic [2:0] viol_code;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  typedef struct {
    logic [2:0] code;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  ddr_pre_timing_chk dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd),
    .bank_i      (bank),
    .act_ok_o    (act_ok),
    .pre_ok_o    (pre_ok),
    .viol_o      (viol),
    .viol_code_o (viol_code)
  );

  // Monitor: each command's verdict is visible just after its own edge.
  always begin
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      n_chk++;
      if (viol !== (it.code != 0) || viol_code !== it.code) begin
        n_err++;
        $display("FAIL %s: viol=%0b code=%0d, expected viol=%0b code=%0d",
                 it.tag, viol, viol_code, (it.code != 0), it.code);
      end
    end
  end

  task automatic step(input logic [2:0] c, input int b, input logic [2:0] exp, input string tag);
    @(negedge clk);
    cmd  = c;
    bank = 2'(b);
    exp_q.push_back('{exp, tag});
    @(posedge clk);
    #2;
    cmd = NOP;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(NOP, 0, C_NONE, tag);
  endtask

  task automatic flags(input int b, input bit exp_act, input bit exp_pre, input string tag);
    n_chk++;
    if (act_ok[b] !== exp_act || pre_ok[b] !== exp_pre) begin
      n_err++;
      $display("FAIL %s: bank %0d act_ok=%0b pre_ok=%0b, expected act_ok=%0b pre_ok=%0b",
               tag, b, act_ok[b], pre_ok[b], exp_act, exp_pre);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_sim();
  end

  initial begin
    rst_n = 1'b0;
    cmd   = NOP;
    bank  = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;

    // R1: reset state
    for (int b = 0; b < 4; b++) flags(b, 1, 0, "R1");
    n_chk++;
    if (viol !== 1'b0) begin
      n_err++;
      $display("FAIL R1: viol=%0b, expected 0", viol);
    end

    // R2 / R3: tRAS on bank 0 (TRAS_CYC = 8)
    step(ACT, 0, C_NONE, "R2");
    flags(0, 0, 0, "R2");
    idle(6, "R9");
    flags(0, 0, 0, "R2");
    step(PRE, 0, C_PRE_TRAS, "R3");
    flags(0, 0, 1, "R3");
    // R4: precharge one cycle after READ, then tRP = ceil(18000/5000) = 4
    step(RD, 0, C_NONE, "R4");
    step(PRE, 0, C_NONE, "R4");
    flags(0, 0, 0, "R4");
    step(ACT, 0, C_ACT_TRP, "R4");
    step(NOP, 0, C_NONE, "R9");
    flags(0, 0, 0, "R4");
    step(NOP, 0, C_NONE, "R4");
    flags(0, 1, 0, "R4");
    step(ACT, 0, C_NONE, "R4");
    step(ACT, 0, C_ACT_OPEN, "R5");

    // R6 / R8 / R11 on idle bank 1 while bank 0 waits for tRAS (R10)
    step(RD, 1, C_RD_CLOSED, "R6");
    step(PRE, 1, C_NONE, "R8");
    step(3'd6, 1, C_NONE, "R11");
    flags(1, 1, 0, "R11");
    flags(0, 0, 0, "R10");
    idle(4, "R9");
    flags(0, 0, 1, "R10");

    // R4: earliest non-truncating precharge, READ at r, PRE at r+4
    step(RD, 0, C_NONE, "R4");
    idle(3, "R4");
    step(PRE, 0, C_NONE, "R4");
    flags(0, 0, 0, "R4");
    idle(2, "R4");
    flags(0, 0, 0, "R4");
    idle(1, "R4");
    flags(0, 1, 0, "R4");

    // R7: autoprecharge on bank 2 held back by tRAS (start a+8, free after a+11)
    step(ACT, 2, C_NONE, "R7");
    step(RDA, 2, C_NONE, "R7");
    flags(2, 0, 0, "R7");
    step(PRE, 2, C_PRE_AP, "R8");
    step(RD, 2, C_RD_CLOSED, "R6");
    idle(4, "R7");
    step(ACT, 1, C_NONE, "R10");
    idle(2, "R7");
    flags(2, 0, 0, "R7");
    flags(1, 0, 0, "R10");
    idle(1, "R7");
    flags(2, 1, 0, "R7");

    // R7: autoprecharge on bank 3 after tRAS is met (start r+4, free after r+7)
    step(ACT, 3, C_NONE, "R7");
    idle(8, "R7");
    step(RDA, 3, C_NONE, "R7");
    step(ACT, 3, C_ACT_OPEN, "R5");
    idle(5, "R7");
    flags(3, 0, 0, "R7");
    idle(1, "R7");
    flags(3, 1, 0, "R7");

    repeat (3) @(posedge clk);
    #3;
    finish_sim();
  end
endmodule